// File: doc/BRIEF.md
# Hashed One-Bit Combined Branch Direction Predictor

This block predicts whether a conditional branch is taken by consulting two single-bit component predictors and a single-bit chooser. The local component is indexed directly by bits of the fetch address. The global component and the chooser share a second index. That index is built by XOR-ing a global outcome history into the low address index bits. The fetch-side lookup is combinational. It returns the final direction, both component guesses and the chooser bit.

When a branch resolves, the front end presents its address and real outcome for one cycle. The block then writes the outcome into both component entries. It repoints the chooser entry toward whichever component was right, but only if the two components disagreed. It also shifts the outcome into the history. Both lookup and update use the history as it stands, so no speculative history is kept. Full-size use sets a 14-bit index and an 11-bit history, which gives three 16K-entry tables. The defaults are smaller.

Top module: `cbp_hashed_combo`

## Requirements
- R1: After reset every table bit and the history are 0, so every address reads pred_local=0, pred_global=0, pred_sel=0 and pred_taken=0.
- R2: The local entry is selected by fetch_addr[ADDR_LSB +: IDX_W] alone. Address bits outside that field have no effect on any output.
- R3: The global entry index equals the address index field with its low HIST_W bits XOR-ed with the history; the upper IDX_W-HIST_W index bits pass through unchanged.
- R4: The chooser entry is read at the same hashed index as the global entry. pred_sel=1 means the global component is chosen, and 0 means local.
- R5: pred_taken equals pred_global when pred_sel=1 and pred_local when pred_sel=0.
- R6: A cycle with resolve_valid=1 writes resolve_taken into the local entry at the resolve address's plain index and into the global entry at its hashed index. Both indices are formed with the history from before the update.
- R7: On a resolve, the chooser entry at the hashed index changes only when the local and global entries read there disagree. It is then set to 1 if the global entry equalled resolve_taken, else 0.
- R8: Each resolve shifts the history left by one with resolve_taken entering at bit 0.
- R9: While resolve_valid=0, changes on resolve_addr and resolve_taken leave all tables and the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | ADDR_W | Address being looked up |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_local | output | 1 | Local component guess |
| pred_global | output | 1 | Global component guess |
| pred_sel | output | 1 | Chooser bit (1 = global) |
| resolve_valid | input | 1 | Resolve strobe, one cycle per branch |
| resolve_addr | input | ADDR_W | Address of the resolved branch |
| resolve_taken | input | 1 | Real outcome of the resolved branch |

## Verification
A small configuration with a 4-bit index and a 3-bit history is driven in three phases. An all-taken run fills the history with ones and shows that the hash moves global and chooser lookups away from the local slot. An alternating outcome run makes the components disagree often, which exercises the conditional chooser rewrite. A pseudo-random address and outcome run mixes every case. After each resolve, all 16 index values are swept with random upper and lower address bits, and all four outputs are compared against an arithmetic model. Idle stretches with a toggling resolve address and outcome but no strobe show that nothing moves without resolve_valid.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
   typedef enum logic {
      SEL_LOCAL  = 1'b0,
      SEL_GLOBAL = 1'b1
   } cbp_sel_e;

   function automatic cbp_sel_e cbp_better(input logic loc_bit,
                                           input logic glb_bit,
                                           input logic outcome,
                                           input cbp_sel_e keep);
      if (loc_bit == glb_bit) return keep;
      return (glb_bit == outcome) ? SEL_GLOBAL : SEL_LOCAL;
   endfunction
endpackage

// File: rtl/cbp_index_hash.sv
module cbp_index_hash #(
   parameter int IDX_W  = 8,
   parameter int HIST_W = 6
) (
   input  logic [IDX_W-1:0]  addr_idx,
   input  logic [HIST_W-1:0] hist,
   output logic [IDX_W-1:0]  hashed_idx
);
   generate
      if (HIST_W == IDX_W) begin : g_full
         assign hashed_idx = addr_idx ^ hist;
      end else begin : g_part
         assign hashed_idx = {addr_idx[IDX_W-1:HIST_W],
                              addr_idx[HIST_W-1:0] ^ hist};
      end
   endgenerate
endmodule

// File: rtl/cbp_bit_table.sv
module cbp_bit_table #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_a_idx,
   output logic             rd_a_bit,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic             rd_b_bit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bits_q <= '0;
      else if (wr_en) bits_q[wr_idx] <= wr_bit;
   end

   assign rd_a_bit = bits_q[rd_a_idx];
   assign rd_b_bit = bits_q[rd_b_idx];

   // R6: a write lands at its index
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bits_q[$past(wr_idx)] == $past(wr_bit));

   // R9: no write strobe, no change
   a_r9_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bits_q));
endmodule

// File: rtl/cbp_ghist.sv
module cbp_ghist #(
   parameter int HIST_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist <= '0;
      else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
   end

   // R8: outcome enters at bit 0, older bits move up
   a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (hist[0] == $past(shift_bit)) &&
                   (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

   // R9: history holds without a resolve
   a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist));
endmodule

// File: rtl/cbp_hashed_combo.sv
module cbp_hashed_combo
   import cbp_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int ADDR_LSB = 2,
   parameter int IDX_W    = 8,
   parameter int HIST_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              pred_taken,
   output logic              pred_local,
   output logic              pred_global,
   output logic              pred_sel,
   input  logic              resolve_valid,
   input  logic [ADDR_W-1:0] resolve_addr,
   input  logic              resolve_taken
);
   localparam int IDX_TOP = ADDR_LSB + IDX_W;

   generate
      if (HIST_W < 2 || HIST_W > IDX_W) begin : g_bad_hist
         $error("HIST_W must lie in 2..IDX_W");
      end
      if (ADDR_LSB < 1 || ADDR_W <= IDX_TOP) begin : g_bad_addr
         $error("address must have bits below and above the index field");
      end
   endgenerate

   logic [IDX_W-1:0]  f_idx, r_idx, f_hidx, r_hidx;
   logic [HIST_W-1:0] hist;
   logic              r_loc, r_glb, r_sel, sel_we;
   cbp_sel_e          f_sel, r_sel_next;

   assign f_idx = fetch_addr[IDX_TOP-1:ADDR_LSB];
   assign r_idx = resolve_addr[IDX_TOP-1:ADDR_LSB];

   logic unused_addr_bits;
   assign unused_addr_bits = ^{fetch_addr[ADDR_LSB-1:0], fetch_addr[ADDR_W-1:IDX_TOP],
                               resolve_addr[ADDR_LSB-1:0], resolve_addr[ADDR_W-1:IDX_TOP]};

   cbp_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_fhash (
      .addr_idx(f_idx), .hist(hist), .hashed_idx(f_hidx));

   cbp_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_rhash (
      .addr_idx(r_idx), .hist(hist), .hashed_idx(r_hidx));

   cbp_bit_table #(.IDX_W(IDX_W)) u_local (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(f_idx), .rd_a_bit(pred_local),
      .rd_b_idx(r_idx), .rd_b_bit(r_loc),
      .wr_en(resolve_valid), .wr_idx(r_idx), .wr_bit(resolve_taken));

   cbp_bit_table #(.IDX_W(IDX_W)) u_global (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(f_hidx), .rd_a_bit(pred_global),
      .rd_b_idx(r_hidx), .rd_b_bit(r_glb),
      .wr_en(resolve_valid), .wr_idx(r_hidx), .wr_bit(resolve_taken));

   assign r_sel_next = cbp_better(r_loc, r_glb, resolve_taken, cbp_sel_e'(r_sel));
   assign sel_we     = resolve_valid && (r_loc != r_glb);

   cbp_bit_table #(.IDX_W(IDX_W)) u_chooser (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(f_hidx), .rd_a_bit(pred_sel),
      .rd_b_idx(r_hidx), .rd_b_bit(r_sel),
      .wr_en(sel_we), .wr_idx(r_hidx), .wr_bit(r_sel_next));

   cbp_ghist #(.HIST_W(HIST_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .shift_en(resolve_valid), .shift_bit(resolve_taken), .hist(hist));

   assign f_sel      = cbp_sel_e'(pred_sel);
   assign pred_taken = (f_sel == SEL_GLOBAL) ? pred_global : pred_local;
endmodule

// File: tb/cbp_hashed_combo_test.sv
`timescale 1ns/100ps
module cbp_hashed_combo_test;
   localparam int AW = 8, LSB = 2, IW = 4, HW = 3, N = 16;

   logic clk = 0, rst_n = 0;
   logic [AW-1:0] fetch_addr = '0, resolve_addr = '0;
   logic resolve_valid = 0, resolve_taken = 0;
   logic pred_taken, pred_local, pred_global, pred_sel;

   int checks = 0, errors = 0;
   logic m_loc [N], m_glb [N], m_sel [N];
   logic [HW-1:0] m_hist;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   cbp_hashed_combo #(.ADDR_W(AW), .ADDR_LSB(LSB), .IDX_W(IW), .HIST_W(HW)) uut (
      .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
      .pred_taken(pred_taken), .pred_local(pred_local),
      .pred_global(pred_global), .pred_sel(pred_sel),
      .resolve_valid(resolve_valid), .resolve_addr(resolve_addr),
      .resolve_taken(resolve_taken));

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s addr=%h actual=%b expected=%b", req, fetch_addr, act, exp);
      end
   endtask

   function automatic logic [IW-1:0] hidx(input logic [IW-1:0] i);
      return {i[IW-1:HW], i[HW-1:0] ^ m_hist};
   endfunction

   // sweep every index with scrambled unused address bits
   task automatic sweep(input string tag);
      for (int i = 0; i < N; i++) begin
         logic [IW-1:0] li, gi;
         logic el, eg, es;
         step_lfsr();
         li = IW'(i);
         gi = hidx(li);
         el = m_loc[li]; eg = m_glb[gi]; es = m_sel[gi];
         fetch_addr = {lfsr[1:0], li, lfsr[3:2]};
         #0.1;
         chk({tag, " R2 local"}, pred_local, el);
         chk({tag, " R3 global"}, pred_global, eg);
         chk({tag, " R4 chooser"}, pred_sel, es);
         chk({tag, " R5 final"}, pred_taken, es ? eg : el);
      end
   endtask

   task automatic resolve(input logic [AW-1:0] a, input logic t);
      logic [IW-1:0] li, gi;
      logic l, g;
      @(negedge clk);
      resolve_valid = 1; resolve_addr = a; resolve_taken = t;
      li = a[LSB +: IW];
      gi = hidx(li);
      l = m_loc[li]; g = m_glb[gi];
      if (l != g) m_sel[gi] = (g == t);   // R7
      m_loc[li] = t; m_glb[gi] = t;       // R6
      m_hist = {m_hist[HW-2:0], t};       // R8
      @(negedge clk);
      resolve_valid = 0;
      #0.2;
      sweep("R6/R7/R8");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_loc[i] = 0; m_glb[i] = 0; m_sel[i] = 0; end
      m_hist = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      sweep("R1 reset");
      // phase 1: all taken, history fills with ones (R3 hash shift)
      for (int k = 0; k < 40; k++) begin
         step_lfsr();
         resolve(lfsr[7:0], 1'b1);
      end
      // phase 2: alternating outcomes provoke disagreement (R7)
      for (int k = 0; k < 80; k++) begin
         step_lfsr();
         resolve(lfsr[7:0], k[0]);
      end
      // phase 3: pseudo-random mix
      for (int k = 0; k < 180; k++) begin
         step_lfsr();
         resolve(lfsr[7:0], lfsr[9]);
         if (k % 30 == 0) begin
            // R9: strobe low while resolve fields toggle
            for (int j = 0; j < 6; j++) begin
               @(negedge clk);
               step_lfsr();
               resolve_addr = lfsr[7:0];
               resolve_taken = lfsr[4];
            end
            @(negedge clk);
            sweep("R9 idle");
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule